// File: doc/BRIEF.md
# Reciprocal square root Newton refiner

This block sharpens a reduced-precision estimate of 1/sqrt(b). A request carries an operand b and a seed x that is already good to roughly 16 bits. The block runs one or two Newton-Raphson passes and returns the refined estimate. Each pass takes three steps, one clock each:

- **Product step:** forms p = b·x.
- **Residual step:** forms the halved residual r = (1 − p·x)/2.
- **Correction step:** forms the multiply-add x' = x + x·r. The new x' becomes the estimate for the next pass.

All steps truncate; no rounding mode applies. One pass takes a 16-bit seed to single-precision accuracy. Two chained passes are used when a double-precision target is wanted.

Operands and estimates are unsigned Q2.30 mantissas, with 2 integer bits and 30 fractional bits. Two lanes exist:

- **Single mode:** only lane 0 is reported, and lane 1 reads as zero.
- **Paired mode:** both lanes refine independent operand/seed pairs in lockstep.

Both the pass count and the mode are chosen per request. An operand below 1.0, or a zero seed, raises that lane's error flag. The lane still finishes in the normal time.

Sequencing is a state machine with six states:

- **IDLE:** waiting for a request; ready is high.
- **PROD**, **RESID**, **CORR:** the three steps of a pass.
- **LOAD:** fills the output registers.
- **HOLD:** presents the result.

The transitions are:

- **accept:** IDLE→PROD, taken when in_valid is high in IDLE.
- **step:** PROD→RESID and RESID→CORR.
- **repass:** CORR→PROD, taken when two passes were requested and the first has just ended.
- **finish:** CORR→LOAD.
- **present:** LOAD→HOLD.
- **release:** HOLD→IDLE, taken on out_ready.

Top module: `invsqrt_refiner`

## Requirements
- R1: A request is taken only on a rising edge where in_valid and in_ready are both high. in_ready is low from that edge until the edge where out_valid and out_ready are both high, and it is high again in the cycle after that edge.
- R2: out_valid rises exactly 4 clock edges after the accepting edge when in_two_pass=0, and exactly 7 edges after it when in_two_pass=1 (3 per pass plus one output stage).
- R3: While out_valid is high and out_ready is low, out_valid stays high and out_y0/out_y1 keep their values.
- R4: With in_two_pass=0 and a seed within 2^-16 of 1/sqrt(b), out_y0 is within 2^-22 of 1/sqrt(b). Values are read as Q2.30, so value = code/2^30.
- R5: With in_two_pass=1 and a seed within 2^-10 of 1/sqrt(b), the result is within 2^-28 of 1/sqrt(b).
- R6: With in_paired=1, lane 1 refines in_b1/in_x1 into out_y1, bit-identical to what lane 0 gives for the same pair, and neither lane affects the other.
- R7: With in_paired=0, out_y1 is zero and out_err1 is 0, whatever in_b1/in_x1 hold.
- R8: out_errN is 1 exactly when that lane's operand is below 1.0 (code < 0x40000000) or its seed is zero. The latency of R2 is unchanged when a flag is set.
- R9: After reset: in_ready=1, out_valid=0, both results zero, both error flags 0.
- R10: For b=1.0 and x=1.0 (code 0x40000000), the residual is zero and the result is exactly 0x40000000 after one or two passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request (state IDLE) |
| in_two_pass | input | 1 | 1 = two refinement passes, 0 = one |
| in_paired | input | 1 | 1 = both lanes active, 0 = lane 0 only |
| in_b0 | input | 32 | Lane 0 operand, Q2.30 |
| in_x0 | input | 32 | Lane 0 seed estimate, Q2.30 |
| in_b1 | input | 32 | Lane 1 operand, Q2.30 |
| in_x1 | input | 32 | Lane 1 seed estimate, Q2.30 |
| out_valid | output | 1 | Result present (state HOLD) |
| out_ready | input | 1 | Consumer takes the result |
| out_y0 | output | 32 | Lane 0 refined estimate, Q2.30 |
| out_err0 | output | 1 | Lane 0 domain error |
| out_y1 | output | 32 | Lane 1 refined estimate, Q2.30, zero in single mode |
| out_err1 | output | 1 | Lane 1 domain error, 0 in single mode |

## Verification
The bench builds the block with its defaults: 2 integer bits, 30 fractional bits and 8 residual guard bits. At that width the truncation floor of a pass is a few units of 2^-30. This leaves room to check one-pass results against 2^-22 and two-pass results against 2^-28. A table of operands spans the Q2.30 range from 1.0 up to the largest code, with seeds offset both ways, across both modes and both pass counts. Directed runs then cover:
- the exact fixed point at b=1.0;
- bit-exact lane independence;
- domain flags on each lane with the latency unchanged;
- held results under back-pressure.

// File: rtl/invsqrt_pkg.sv
package invsqrt_pkg;

    // Sequencer states: three per refinement pass, then load and hold.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROD  = 3'd1,
        ST_RESID = 3'd2,
        ST_CORR  = 3'd3,
        ST_LOAD  = 3'd4,
        ST_HOLD  = 3'd5
    } step_e;

    localparam int STEPS_PER_PASS = 3;

    // Edges from the accepting edge until out_valid rises.
    function automatic int result_latency(input logic two_pass);
        return (two_pass ? 2 * STEPS_PER_PASS : STEPS_PER_PASS) + 1;
    endfunction

endpackage

// File: rtl/invsqrt_ctrl.sv
module invsqrt_ctrl
    import invsqrt_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_two_pass,
    input  logic in_paired,
    input  logic out_ready,
    output logic in_ready,
    output logic accept,
    output logic do_prod,
    output logic do_resid,
    output logic do_corr,
    output logic do_load,
    output logic out_valid,
    output logic paired_q
);

    localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

    step_e state_q;
    step_e state_d;
    logic  two_q;
    logic  pass_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request attributes captured on accept, pass index advanced in CORR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            two_q    <= 1'b0;
            paired_q <= 1'b0;
            pass_q   <= 1'b0;
        end else if (accept) begin
            two_q    <= in_two_pass;
            paired_q <= in_paired;
            pass_q   <= 1'b0;
        end else if (do_corr) begin
            pass_q   <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_PROD;
            ST_PROD:  state_d = ST_RESID;
            ST_RESID: state_d = ST_CORR;
            ST_CORR:  state_d = (two_q && !pass_q) ? ST_PROD : ST_LOAD;
            ST_LOAD:  state_d = ST_HOLD;
            ST_HOLD:  if (out_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        in_ready  = 1'b0;
        accept    = 1'b0;
        do_prod   = 1'b0;
        do_resid  = 1'b0;
        do_corr   = 1'b0;
        do_load   = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                accept   = in_valid;
            end
            ST_PROD:  do_prod   = 1'b1;
            ST_RESID: do_resid  = 1'b1;
            ST_CORR:  do_corr   = 1'b1;
            ST_LOAD:  do_load   = 1'b1;
            ST_HOLD:  out_valid = 1'b1;
            default:  ;
        endcase
    end

    // Cycle counter used only by the latency check
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (accept) begin
            lat_q <= '0;
        end else if (lat_q != LAT_MAX) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R1
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R1
    ready_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (int'(lat_q) == result_latency(two_q)));

endmodule

// File: rtl/invsqrt_lane.sv
module invsqrt_lane #(
    parameter int INT_W   = 2,
    parameter int FRAC_W  = 30,
    parameter int GUARD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic                    do_prod,
    input  logic                    do_resid,
    input  logic                    do_corr,
    input  logic                    do_load,
    input  logic                    lane_on,
    input  logic [INT_W+FRAC_W-1:0] b_in,
    input  logic [INT_W+FRAC_W-1:0] x_in,
    output logic [INT_W+FRAC_W-1:0] y_out,
    output logic                    err_out
);

    localparam int W  = INT_W + FRAC_W;
    localparam int PW = 2 * W;             // full product width
    localparam int DW = PW + 2;            // signed residual before scaling
    localparam int SH = FRAC_W + 1 - GUARD_W;  // halve and drop to residual scale
    localparam int RW = DW - SH;           // residual register width
    localparam int RF = FRAC_W + GUARD_W;  // residual fractional bits
    localparam int XW = W + 1 + RW;        // correction product width

    localparam logic [W-1:0]  ONE    = W'(1) << FRAC_W;
    localparam logic [DW-1:0] ONE_SQ = DW'(1) << (2 * FRAC_W);

    logic [W-1:0]         b_q;
    logic [W-1:0]         x_q;
    logic [W-1:0]         p_q;
    logic signed [RW-1:0] r_q;
    logic                 err_q;

    logic [W-1:0]         p_next;
    logic signed [RW-1:0] r_next;
    logic signed [W:0]    x_s;
    logic [W-1:0]         x_next;

    // Product step: p = b * x, truncated back to operand scale
    assign p_next = W'((PW'(b_q) * PW'(x_q)) >> FRAC_W);

    // Residual step: (1 - p * x) / 2, truncated toward minus infinity
    assign r_next = RW'(($signed(ONE_SQ) - $signed(DW'(PW'(p_q) * PW'(x_q)))) >>> SH);

    // Correction step: x + x * r
    assign x_s    = $signed({1'b0, x_q});
    assign x_next = x_q + W'((XW'(x_s) * XW'(r_q)) >>> RF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q   <= '0;
            x_q   <= '0;
            p_q   <= '0;
            r_q   <= '0;
            err_q <= 1'b0;
        end else begin
            if (accept) begin
                b_q   <= b_in;
                x_q   <= x_in;
                err_q <= (b_in < ONE) || (x_in == '0);
            end
            if (do_prod) begin
                p_q <= p_next;
            end
            if (do_resid) begin
                r_q <= r_next;
            end
            if (do_corr) begin
                x_q <= x_next;
            end
        end
    end

    // Output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_out   <= '0;
            err_out <= 1'b0;
        end else if (do_load) begin
            y_out   <= lane_on ? x_q : '0;
            err_out <= lane_on && err_q;
        end
    end

    // R10
    zero_resid_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_corr && (r_q == '0)) |=> (x_q == $past(x_q)));

endmodule

// File: rtl/invsqrt_refiner.sv
module invsqrt_refiner
    import invsqrt_pkg::*;
#(
    parameter int INT_W   = 2,
    parameter int FRAC_W  = 30,
    parameter int GUARD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_two_pass,
    input  logic                    in_paired,
    input  logic [INT_W+FRAC_W-1:0] in_b0,
    input  logic [INT_W+FRAC_W-1:0] in_x0,
    input  logic [INT_W+FRAC_W-1:0] in_b1,
    input  logic [INT_W+FRAC_W-1:0] in_x1,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [INT_W+FRAC_W-1:0] out_y0,
    output logic                    out_err0,
    output logic [INT_W+FRAC_W-1:0] out_y1,
    output logic                    out_err1
);

    localparam int W     = INT_W + FRAC_W;
    localparam int LANES = 2;

    logic accept;
    logic do_prod;
    logic do_resid;
    logic do_corr;
    logic do_load;
    logic paired_q;

    logic [W-1:0] b_arr   [LANES];
    logic [W-1:0] x_arr   [LANES];
    logic [W-1:0] y_arr   [LANES];
    logic         err_arr [LANES];

    assign b_arr[0] = in_b0;
    assign b_arr[1] = in_b1;
    assign x_arr[0] = in_x0;
    assign x_arr[1] = in_x1;

    invsqrt_ctrl #(
        .LAT_W (4)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_two_pass (in_two_pass),
        .in_paired   (in_paired),
        .out_ready   (out_ready),
        .in_ready    (in_ready),
        .accept      (accept),
        .do_prod     (do_prod),
        .do_resid    (do_resid),
        .do_corr     (do_corr),
        .do_load     (do_load),
        .out_valid   (out_valid),
        .paired_q    (paired_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic on;
        if (g == 0) begin : g_primary
            assign on = 1'b1;
        end else begin : g_partner
            assign on = paired_q;
        end

        invsqrt_lane #(
            .INT_W   (INT_W),
            .FRAC_W  (FRAC_W),
            .GUARD_W (GUARD_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .accept   (accept),
            .do_prod  (do_prod),
            .do_resid (do_resid),
            .do_corr  (do_corr),
            .do_load  (do_load),
            .lane_on  (on),
            .b_in     (b_arr[g]),
            .x_in     (x_arr[g]),
            .y_out    (y_arr[g]),
            .err_out  (err_arr[g])
        );
    end

    assign out_y0   = y_arr[0];
    assign out_y1   = y_arr[1];
    assign out_err0 = err_arr[0];
    assign out_err1 = err_arr[1];

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_y0) && $stable(out_y1)));

    // R7
    lane1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !paired_q) |-> ((out_y1 == '0) && !out_err1));

endmodule

// File: tb/sim_invsqrt_refiner.sv
module sim_invsqrt_refiner;

    localparam int NV = 10;
    localparam logic [31:0] ONE = 32'h4000_0000;

    localparam logic [31:0] VB [NV] = '{
        32'h4000_0000, 32'h6000_0000, 32'h8000_0000, 32'hC000_0000, 32'hFFFF_FFFF,
        32'h4F0A_3D71, 32'hACCC_CCCD, 32'h4000_0007, 32'h9E14_7AE1, 32'h5555_5555
    };
    localparam int VOFF [NV] = '{
        16384, -16384, 9000, -12000, 16000,
        -7000, 1048576, -1048576, 524288, -300000
    };
    localparam logic [NV-1:0] VTWO  = 10'b11_1100_0000;
    localparam logic [NV-1:0] VPAIR = 10'b10_1010_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, in_two_pass, in_paired;
    logic [31:0] in_b0, in_x0, in_b1, in_x1;
    logic        out_valid, out_ready;
    logic [31:0] out_y0, out_y1;
    logic        out_err0, out_err1;

    always #5 clk = ~clk;

    invsqrt_refiner u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_two_pass(in_two_pass), .in_paired(in_paired),
        .in_b0(in_b0), .in_x0(in_x0), .in_b1(in_b1), .in_x1(in_x1),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_y0(out_y0), .out_err0(out_err0),
        .out_y1(out_y1), .out_err1(out_err1)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] ry0, ry1;
    logic        re0, re1;
    int          lat;
    bit          busy_ok, hold_ok, rel_ok;

    function automatic real q2r(input logic [31:0] v);
        return real'(longint'({32'd0, v})) / 1073741824.0;
    endfunction

    function automatic logic [31:0] seed(input logic [31:0] b, input int off);
        real t;
        t = 1.0 / $sqrt(q2r(b));
        return 32'($rtoi(t * 1073741824.0) + off);
    endfunction

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic check_acc(input string tag, input logic [31:0] b, input logic [31:0] y,
                             input real tol);
        real want, got, d;
        want = 1.0 / $sqrt(q2r(b));
        got  = q2r(y);
        d    = got - want;
        if (d < 0.0) d = -d;
        check(d <= tol, tag, $sformatf("b=%h actual %.12f expected %.12f", b, got, want));
    endtask

    task automatic run_op(input logic [31:0] b0, input logic [31:0] x0,
                          input logic [31:0] b1, input logic [31:0] x1,
                          input logic two, input logic pair, input int hold);
        busy_ok = 1'b1;
        hold_ok = 1'b1;
        rel_ok  = 1'b1;
        @(negedge clk);
        in_b0 = b0; in_x0 = x0; in_b1 = b1; in_x1 = x1;
        in_two_pass = two; in_paired = pair; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        lat = 0;
        forever begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid) break;
            if (in_ready) busy_ok = 1'b0;
            if (lat >= 40) break;
            @(posedge clk);
            lat++;
        end
        ry0 = out_y0; ry1 = out_y1; re0 = out_err0; re1 = out_err1;
        repeat (hold) begin
            @(negedge clk);
            if (!out_valid || out_y0 != ry0 || out_y1 != ry1 || in_ready) hold_ok = 1'b0;
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        if (out_valid || !in_ready) rel_ok = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int          j;
        int          exp_lat;
        real         tol;
        logic [31:0] s0, s1, keep0, keep1;

        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_two_pass = 1'b0; in_paired = 1'b0;
        in_b0 = '0; in_x0 = '0; in_b1 = '0; in_x1 = '0;
        repeat (3) @(negedge clk);

        // R9 reset state
        check(in_ready && !out_valid, "R9",
              $sformatf("ready/valid actual %b/%b expected 1/0", in_ready, out_valid));
        check(out_y0 == '0 && out_y1 == '0 && !out_err0 && !out_err1, "R9",
              $sformatf("outputs actual %h %h %b %b expected 0", out_y0, out_y1, out_err0, out_err1));
        rst_n = 1'b1;

        // R1 nothing accepted while in_valid is low
        repeat (5) begin
            @(negedge clk);
            check(in_ready && !out_valid, "R1",
                  $sformatf("idle ready/valid actual %b/%b expected 1/0", in_ready, out_valid));
        end

        // Vector table
        for (int i = 0; i < NV; i++) begin
            j  = (i + 3) % NV;
            s0 = seed(VB[i], VOFF[i]);
            s1 = seed(VB[j], -(VOFF[i] / 2));
            run_op(VB[i], s0, VB[j], s1, VTWO[i], VPAIR[i], i % 3);
            tol     = VTWO[i] ? 2.0 ** -28 : 2.0 ** -22;
            exp_lat = VTWO[i] ? 7 : 4;
            check_acc(VTWO[i] ? "R5" : "R4", VB[i], ry0, tol);
            check(lat == exp_lat, "R2", $sformatf("latency actual %0d expected %0d", lat, exp_lat));
            check(busy_ok && rel_ok, "R1",
                  $sformatf("handshake actual busy=%b rel=%b expected 1/1", busy_ok, rel_ok));
            if (i % 3 != 0)
                check(hold_ok, "R3", $sformatf("hold actual %b expected 1", hold_ok));
            check(!re0, "R8", $sformatf("lane0 err actual %b expected 0", re0));
            if (VPAIR[i]) begin
                check_acc(VTWO[i] ? "R5" : "R4", VB[j], ry1, tol);
                check(!re1, "R8", $sformatf("lane1 err actual %b expected 0", re1));
            end else begin
                check(ry1 == '0 && !re1, "R7",
                      $sformatf("lane1 actual %h/%b expected 0/0", ry1, re1));
            end
        end

        // R6 paired lanes equal independent single runs
        s0 = seed(VB[1], 4000);
        s1 = seed(VB[6], -9000);
        run_op(VB[1], s0, VB[6], s1, 1'b0, 1'b1, 0);
        keep0 = ry0; keep1 = ry1;
        run_op(VB[6], s1, 32'h0, 32'h0, 1'b0, 1'b0, 0);
        check(keep1 == ry0, "R6", $sformatf("lane1 actual %h expected %h", keep1, ry0));
        run_op(VB[1], s0, 32'h0, 32'h0, 1'b0, 1'b0, 0);
        check(keep0 == ry0, "R6", $sformatf("lane0 actual %h expected %h", keep0, ry0));

        // R10 exact fixed point at b = 1.0
        run_op(ONE, ONE, ONE, ONE, 1'b0, 1'b1, 0);
        check(ry0 == ONE && ry1 == ONE, "R10",
              $sformatf("one pass actual %h %h expected %h", ry0, ry1, ONE));
        run_op(ONE, ONE, ONE, ONE, 1'b1, 1'b1, 0);
        check(ry0 == ONE && ry1 == ONE, "R10",
              $sformatf("two pass actual %h %h expected %h", ry0, ry1, ONE));

        // R8 domain flags, latency unchanged
        run_op(32'h2000_0000, ONE, 32'h6000_0000, 32'h0, 1'b0, 1'b1, 0);
        check(re0 && re1, "R8", $sformatf("flags actual %b %b expected 1 1", re0, re1));
        check(lat == 4, "R8", $sformatf("flagged latency actual %0d expected 4", lat));
        run_op(32'h0, ONE, ONE, ONE, 1'b1, 1'b1, 0);
        check(re0 && !re1, "R8", $sformatf("flags actual %b %b expected 1 0", re0, re1));
        check(lat == 7, "R8", $sformatf("flagged latency actual %0d expected 7", lat));

        // R7 single mode hides a lane 1 that would flag
        run_op(VB[2], seed(VB[2], 0), 32'h0, 32'h0, 1'b0, 1'b0, 0);
        check(ry1 == '0 && !re1, "R7", $sformatf("lane1 actual %h/%b expected 0/0", ry1, re1));

        // R3 long back-pressure
        run_op(VB[3], seed(VB[3], 100), VB[4], seed(VB[4], -100), 1'b1, 1'b1, 6);
        check(hold_ok && rel_ok, "R3",
              $sformatf("hold/release actual %b/%b expected 1/1", hold_ok, rel_ok));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule